// File: doc/BRIEF.md
# Pipelined Converter Code Corrector

This block is the digital back end of an eleven-stage pipelined analog-to-digital converter. Each pipeline stage hands over a 2-bit code, and stages resolve on a sub-clock that runs at twice the sample rate. As a result, the codes that belong to one sample reach the block one sub-clock apart, with the first stage leading. The block runs on that sub-clock. It gives each stage its own delay line, so the codes of one sample line up.

Once aligned, the stage codes are merged by overlapping addition. Stages 0 to 9 are 1.5-bit stages: codes 0, 1 and 2 stand for the digits -1, 0 and +1. Each of these digits carries half the weight of the digit before it. The last stage is a plain 2-bit fine stage. The redundancy between neighbouring stages absorbs comparator errors in the analog stages.

The merged sum is clamped into the 12-bit range, so an overdriven input never rolls over. The word can then be presented as offset binary, or as two's complement by flipping the top bit. The result is registered and driven out. A control input can park the bus and tell the pad ring to stop driving it.

Top module: `pipe_code_corrector`

## Requirements
- R1: Stage k (k = 0 is the first stage, carried on `stage_codes[2k+1:2k]`) has a delay of NSTAGE-k registers. A stage-k code captured on clock edge e contributes to the word that is visible after edge e+12-k. Stage 0 therefore reaches the output 13 sub-clock cycles after it is presented.
- R2: With aligned codes c0..c10, the word value is 2048 + sum over k=0..9 of (ck-1)*2^(11-k) + (c10-2). A full set of mid codes (ck=1 for k<10, c10=2) gives 2048.
- R3: A code of 3 from stages 0 to 9 is illegal and is used as 2. Stage 10 accepts 3 as a legal value.
- R4: `code_err` rises after the edge that captures an illegal code (a 3 on stages 0 to 9). Once set, only reset clears it.
- R5: A sum below 0 gives 0, and a sum above 4095 gives 4095. No wrap-around occurs.
- R6: With `fmt_twos` low, the word is offset binary: 0 for the most negative input, 4095 for the most positive, and 100000000000 at mid scale.
- R7: With `fmt_twos` high, bit 11 of the word is inverted and the other bits are unchanged. The format is taken from `fmt_twos` on the edge that loads the output register.
- R8: While `out_hiz` is high, `dout_oe` is low and `dout` reads 0. While it is low, `dout_oe` is high and `dout` shows the registered word. Both follow `out_hiz` within the same cycle.
- R9: `out_valid` is low until the 13th edge with `rst_n` high. It is high from then on, until the next reset.
- R10: An edge with `rst_n` low clears every delay line and the sum register. It forces `dout` to 0, `out_valid` to 0 and `code_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock, twice the sample rate |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_codes | input | 22 | Raw 2-bit codes, stage k on bits [2k+1:2k] |
| fmt_twos | input | 1 | High: two's complement, low: offset binary |
| out_hiz | input | 1 | High: release the output bus |
| dout | output | 12 | Corrected output word |
| dout_oe | output | 1 | Drive enable for the output pads |
| out_valid | output | 1 | Output words come from a fully populated code set |
| code_err | output | 1 | Sticky flag for an illegal stage code |

## Verification
Clamping of an illegal code and saturation of the sum can act on the same word. The bench provokes this by presenting 3 on every stage for several cycles: after clamping, every digit is at its top value and the sum runs past full scale. It also mixes random 3s into random words, so that a clamped stage can push a near-full-scale sum over the edge. A cycle-by-cycle model built from the requirement formulas judges each of these words. It clamps first, then saturates, then formats, and compares the result against the port on every cycle alongside the sticky error flag.

// File: rtl/pcc_pkg.sv
// Shared constants for the pipelined converter code corrector.
// Assumes 2-bit stage codes; 1.5-bit stages use only 0..2.
package pcc_pkg;
    localparam int unsigned CODE_W     = 2;
    localparam logic [1:0]  CODE_ZERO  = 2'd0;
    localparam logic [1:0]  CODE_TOP   = 2'd2;
    localparam logic [1:0]  CODE_BAD   = 2'd3;
endpackage

// File: rtl/code_screen.sv
// Screens raw stage codes before they enter the delay lines.
// Stages 0..NSTAGE-2 are 1.5-bit stages: a code of 3 is illegal, is
// replaced by 2, and sets a sticky error flag. The last stage passes as is.
module code_screen
    import pcc_pkg::*;
#(
    parameter int NSTAGE = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*NSTAGE-1:0]      codes_in,
    output logic [2*NSTAGE-1:0]      codes_ok,
    output logic                     err_q
);
    logic bad;

    // Replace illegal coarse-stage codes and note that one was seen.
    always_comb begin
        codes_ok = codes_in;
        bad      = 1'b0;
        for (int k = 0; k < NSTAGE - 1; k++) begin
            if (codes_in[2*k +: 2] == CODE_BAD) begin
                codes_ok[2*k +: 2] = CODE_TOP;
                bad                = 1'b1;
            end
        end
    end

    // Sticky error flag, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_err_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> err_q);
endmodule

// File: rtl/skew_align.sv
// Per-stage delay lines that undo the half-sample stagger of the pipeline.
// Stage k arrives k sub-clocks after stage 0 and is delayed NSTAGE-k
// registers, so every stage of one sample leaves on the same cycle.
module skew_align
    import pcc_pkg::*;
#(
    parameter int NSTAGE = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NSTAGE-1:0] codes,
    output logic [2*NSTAGE-1:0] aligned
);
    localparam int LAST = NSTAGE - 1;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int DEPTH = NSTAGE - k;
        logic [CODE_W-1:0] sr [DEPTH];

        // Shift this stage's code along its own delay line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int j = 0; j < DEPTH; j++) sr[j] <= '0;
            end else begin
                sr[0] <= codes[2*k +: 2];
                for (int j = 1; j < DEPTH; j++) sr[j] <= sr[j-1];
            end
        end

        assign aligned[2*k +: 2] = sr[DEPTH-1];
    end

    assert_last_stage_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> aligned[2*LAST +: 2] == $past(codes[2*LAST +: 2]));
endmodule

// File: rtl/overlap_sum.sv
// Merges the aligned stage codes by overlapping addition and clamps.
// Coarse digit k = code-1 weighs 2^(OUT_W-1-k); the fine stage adds
// code-2. The signed sum is offset by mid scale and held in 0..2^OUT_W-1.
module overlap_sum
    import pcc_pkg::*;
#(
    parameter int NSTAGE = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NSTAGE-1:0] aligned,
    output logic [NSTAGE:0]     sum_q
);
    localparam int OUT_W = NSTAGE + 1;
    localparam int ACC_W = OUT_W + 2;
    localparam int LAST  = NSTAGE - 1;
    localparam logic signed [ACC_W-1:0] MID    = ACC_W'(1 << (OUT_W - 1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << OUT_W) - 1);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] dig;
    logic [CODE_W-1:0]       c;
    logic [OUT_W-1:0]        sat;
    logic                    all_hi, all_lo;

    // Weighted sum of the digits around mid scale.
    always_comb begin
        acc    = MID;
        all_hi = 1'b1;
        all_lo = 1'b1;
        dig    = '0;
        for (int k = 0; k < LAST; k++) begin
            c      = aligned[2*k +: 2];
            dig    = $signed(ACC_W'(c)) - ACC_W'(1);
            acc    = acc + (dig <<< (OUT_W - 1 - k));
            all_hi = all_hi & (c == CODE_TOP);
            all_lo = all_lo & (c == CODE_ZERO);
        end
        c      = aligned[2*LAST +: 2];
        acc    = acc + $signed(ACC_W'(c)) - ACC_W'(2);
        all_hi = all_hi & (c == CODE_BAD);
        all_lo = all_lo & (c == CODE_ZERO);
    end

    // Clamp to the output range so an overdrive never wraps.
    always_comb begin
        if (acc[ACC_W-1])      sat = '0;
        else if (acc > SAT_HI) sat = '1;
        else                   sat = acc[OUT_W-1:0];
    end

    // Register the corrected, clamped word.
    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sat;
    end

    assert_sat_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_hi |=> sum_q == '1);
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        all_lo |=> sum_q == '0);
endmodule

// File: rtl/word_out.sv
// Output stage: applies the number format while loading the output
// register, then gates the bus with the drive enable.
// Assumes the format input is quasi-static; it is sampled every edge.
module word_out #(
    parameter int OUT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_W-1:0] sum,
    input  logic             fmt_twos,
    input  logic             out_hiz,
    output logic [OUT_W-1:0] dout,
    output logic             dout_oe
);
    logic [OUT_W-1:0] q;

    // Load the word, flipping the top bit for two's complement.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {sum[OUT_W-1] ^ fmt_twos, sum[OUT_W-2:0]};
    end

    // Park the bus at zero and release the pads when disabled.
    always_comb begin
        dout_oe = ~out_hiz;
        dout    = out_hiz ? '0 : q;
    end

    assert_low_bits_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q[OUT_W-2:0] == $past(sum[OUT_W-2:0]));
    assert_msb_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_twos)) |-> q[OUT_W-1] != $past(sum[OUT_W-1]));
endmodule

// File: rtl/pipe_code_corrector.sv
// Top of the pipelined converter code corrector. Runs on the sub-clock.
// Chain: screen illegal codes -> align stages -> overlap sum with clamp
// -> format and drive. out_valid marks words built from a full code set.
module pipe_code_corrector #(
    parameter int NSTAGE = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NSTAGE-1:0] stage_codes,
    input  logic                fmt_twos,
    input  logic                out_hiz,
    output logic [NSTAGE:0]     dout,
    output logic                dout_oe,
    output logic                out_valid,
    output logic                code_err
);
    localparam int OUT_W = NSTAGE + 1;
    localparam int LAT   = NSTAGE + 2;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [2*NSTAGE-1:0] codes_ok;
    logic [2*NSTAGE-1:0] aligned;
    logic [OUT_W-1:0]    sum_q;
    logic [CNT_W-1:0]    fill_cnt;

    code_screen #(.NSTAGE(NSTAGE)) u_screen (
        .clk(clk), .rst_n(rst_n), .codes_in(stage_codes),
        .codes_ok(codes_ok), .err_q(code_err));

    skew_align #(.NSTAGE(NSTAGE)) u_align (
        .clk(clk), .rst_n(rst_n), .codes(codes_ok), .aligned(aligned));

    overlap_sum #(.NSTAGE(NSTAGE)) u_sum (
        .clk(clk), .rst_n(rst_n), .aligned(aligned), .sum_q(sum_q));

    word_out #(.OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .sum(sum_q), .fmt_twos(fmt_twos),
        .out_hiz(out_hiz), .dout(dout), .dout_oe(dout_oe));

    // Count edges since reset until the pipeline is fully populated.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fill_cnt <= '0;
        else if (fill_cnt != CNT_W'(LAT)) fill_cnt <= fill_cnt + 1'b1;
    end

    assign out_valid = (fill_cnt == CNT_W'(LAT));

    assert_valid_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
endmodule

// File: tb/pipe_code_corrector_tb.sv
// Self-checking bench: a behavioural model built from the requirement
// formulas predicts every output on every cycle.
module pipe_code_corrector_tb;
    localparam int NS    = 11;
    localparam int OW    = NS + 1;
    localparam int MAXC  = 200;
    localparam int FULL  = (1 << OW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NS-1:0] stage_codes = '0;
    logic            fmt_twos = 1'b0;
    logic            out_hiz = 1'b0;
    logic [OW-1:0]   dout;
    logic            dout_oe, out_valid, code_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int unsigned seed = 32'h1234_5678;
    string tag;
    int seg_id;

    int hist [0:MAXC][0:NS-1];
    bit fmt_hist [0:MAXC];
    bit ill_hist [0:MAXC];
    bit ill_acc;

    pipe_code_corrector #(.NSTAGE(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .stage_codes(stage_codes),
        .fmt_twos(fmt_twos), .out_hiz(out_hiz), .dout(dout),
        .dout_oe(dout_oe), .out_valid(out_valid), .code_err(code_err));

    always #5 clk = ~clk;

    function automatic int nxt();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed >> 8);
    endfunction

    function automatic int code_at(int j, int k);
        int v;
        if (j < 1) return 0;
        v = hist[j][k];
        if (k < NS - 1 && v == 3) v = 2;
        return v;
    endfunction

    // Expected word visible after edge m (R1, R2, R3, R5, R6, R7).
    function automatic int expect_word(int m);
        int acc;
        acc = 1 << (OW - 1);
        for (int k = 0; k < NS; k++) begin
            if (k < NS - 1) acc += (code_at(m - 12 + k, k) - 1) * (1 << (OW - 1 - k));
            else            acc += code_at(m - 12 + k, k) - 2;
        end
        if (acc < 0)    acc = 0;
        if (acc > FULL) acc = FULL;
        if (fmt_hist[m]) acc = acc ^ (1 << (OW - 1));
        return acc;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Choose stimulus for edge j of the current segment and record it.
    task automatic drive(int j);
        int v;
        bit ill;
        ill = 1'b0;
        fmt_twos = 1'b0;
        out_hiz  = 1'b0;
        for (int k = 0; k < NS; k++) begin
            if (seg_id == 1) begin
                if (j <= 40)      begin tag = (j <= 20) ? "R1" : "R2"; v = (k < NS-1) ? nxt() % 3 : nxt() % 4; end
                else if (j <= 50) begin tag = "R5"; v = (k < NS-1) ? 2 : 3; end
                else if (j <= 58) begin tag = "R5"; v = 0; end
                else if (j <= 80) begin tag = "R7"; v = (k < NS-1) ? nxt() % 3 : nxt() % 4; fmt_twos = 1'b1; end
                else if (j <= 92) begin tag = "R8"; v = (k < NS-1) ? nxt() % 3 : nxt() % 4; out_hiz = 1'b1; end
                else              begin tag = "R6"; v = (k == 0) ? 1 + nxt() % 2 : ((k < NS-1) ? nxt() % 3 : nxt() % 4); end
            end else begin
                if (j <= 30)      begin tag = "R3"; v = nxt() % 4; end
                else if (j <= 45) begin tag = "R3"; v = 3; end
                else              begin tag = "R4"; v = nxt() % 4; fmt_twos = 1'(nxt() % 2); end
            end
            hist[j][k] = v;
            stage_codes[2*k +: 2] = 2'(v);
            if (k < NS - 1 && v == 3) ill = 1'b1;
        end
        fmt_hist[j] = fmt_twos;
        ill_hist[j] = ill;
    endtask

    // Compare every output against the model after edge m.
    task automatic check_edge(int m);
        int w;
        ill_acc = ill_acc | ill_hist[m];
        w = expect_word(m);
        chk("R9 out_valid", int'(out_valid), (m >= 13) ? 1 : 0);
        chk("R4 code_err", int'(code_err), int'(ill_acc));
        chk("R8 dout_oe", int'(dout_oe), out_hiz ? 0 : 1);
        chk({tag, " dout"}, int'(dout), out_hiz ? 0 : w);
    endtask

    task automatic run_seg(int n, int s);
        seg_id = s;
        rst_n = 1'b0;
        stage_codes = '0;
        fmt_twos = 1'b0;
        out_hiz = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset dout", int'(dout), 0);
        chk("R10 reset valid", int'(out_valid), 0);
        chk("R10 reset err", int'(code_err), 0);
        ill_acc = 1'b0;
        rst_n = 1'b1;
        drive(1);
        for (int j = 1; j <= n; j++) begin
            @(posedge clk);
            @(negedge clk);
            check_edge(j);
            if (j < n) drive(j + 1);
        end
    endtask

    initial begin
        tag = "R1";
        seg_id = 1;
        run_seg(120, 1);
        run_seg(60, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule